// File: doc/BRIEF.md
# Glitch-Free Serial Clock Freeze Control

This block sits between a bank of twelve divided clocks and the pins that carry them. Each output can be stopped ("frozen") or released on its own. While an output is frozen it sits at logic low. Its divider is not touched, so the divider keeps counting underneath. When the output is released it therefore lines up exactly with the outputs that were never stopped.

The freeze mask arrives over a slow serial port made of a serial clock, a data line and a load strobe. The port collects a 12-bit frame and passes it to a shadow register. A toggle flag, brought across by a two-flop synchronizer, hands the shadow register to the fast clock domain. Each output takes its new freeze state only while its own raw clock is low. As a result, a pulse on any output is always a whole high phase of its raw clock, never a cut-off fragment.

Top module: `clk_freeze_ctrl`

## Requirements
- R1: While reset is asserted, and after reset is released until the first valid frame, no output is frozen and every output equals its raw clock.
- R2: Serial data is sampled on the rising edge of the serial clock when the load strobe is low. The first bit shifted in lands in mask bit 11 (MSB first), and mask bit i = 1 freezes output i.
- R3: A rising serial clock edge with the load strobe high commits the frame only if at least 12 data bits arrived since the previous load edge. When more than 12 bits arrived, the last 12 bits form the frame.
- R4: A load edge that comes after fewer than 12 data bits discards those bits and leaves the active mask unchanged.
- R5: A frozen output is held at logic low.
- R6: The freeze state of output i changes only at a fast clock edge where raw clock i is sampled low. Every output pulse is therefore exactly one full high phase of its raw clock.
- R7: An output that is not frozen equals its raw clock on every cycle. After a release, it follows its raw clock edge for edge.
- R8: A committed frame reaches the active mask at the third fast clock rising edge after the serial clock edge that carries the load strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock; the raw clocks are synchronous to it |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| raw_clk_i | input | 12 | Divided clocks before gating |
| ser_clk_i | input | 1 | Serial port clock, rising-edge active |
| ser_data_i | input | 1 | Serial frame data, MSB first |
| ser_load_i | input | 1 | Load strobe, sampled on the serial clock rising edge |
| gclk_o | output | 12 | Gated clocks |

## Verification
The assertions assume three things. Each raw clock changes only between fast clock rising edges. Each high or low phase of a raw clock lasts at least one fast cycle. The shadow register holds still from a commit until the toggle has crossed over, because frames are spaced by many slow serial edges. The bench keeps to these assumptions. It changes every input on the fast clock falling edge and places each serial edge four fast cycles apart. It sets the data line up a full fast cycle before the serial clock rises. This makes the crossing latency fixed, so the reference model can predict the exact fast cycle in which a new mask takes effect.

// File: rtl/clk_freeze_pkg.sv
package clk_freeze_pkg;
  // number of gated outputs, also the serial frame length
  localparam int unsigned CF_NUM_OUT    = 12;
  // synchronizer depth for the commit toggle and for reset release
  localparam int unsigned CF_SYNC_DEPTH = 2;
endpackage

// File: rtl/cf_rst_sync.sv
module cf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/cf_serial_rx.sv
module cf_serial_rx #(
  parameter int unsigned W = 12
) (
  input  logic         sclk_i,
  input  logic         srst_ni,
  input  logic         sdat_i,
  input  logic         sload_i,
  output logic [W-1:0] shadow_o,
  output logic         toggle_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

  logic [W-1:0]     shift_q, shift_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     shadow_q, shadow_d;
  logic             tog_q, tog_d;
  logic             frame_ok;

  assign frame_ok = (cnt_q == FULL);

  always_comb begin
    shift_d  = shift_q;
    cnt_d    = cnt_q;
    shadow_d = shadow_q;
    tog_d    = tog_q;
    if (sload_i) begin
      cnt_d = '0;
      if (frame_ok) begin
        shadow_d = shift_q;
        tog_d    = ~tog_q;
      end
    end else begin
      shift_d = {shift_q[W-2:0], sdat_i};
      if (!frame_ok) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge sclk_i or negedge srst_ni) begin
    if (!srst_ni) begin
      shift_q  <= '0;
      cnt_q    <= '0;
      shadow_q <= '0;
      tog_q    <= 1'b0;
    end else begin
      shift_q  <= shift_d;
      cnt_q    <= cnt_d;
      shadow_q <= shadow_d;
      tog_q    <= tog_d;
    end
  end

  assign shadow_o = shadow_q;
  assign toggle_o = tog_q;
endmodule

// File: rtl/cf_mask_xfer.sv
module cf_mask_xfer #(
  parameter int unsigned W      = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] shadow_i,
  input  logic         toggle_i,
  output logic [W-1:0] mask_o,
  output logic         load_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              seen_q, seen_d;
  logic [W-1:0]      mask_q, mask_d;
  logic              load_en;

  // the toggle flips once per committed frame; a change marks new shadow data
  assign load_en = sync_q[STAGES-1] ^ seen_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], toggle_i};
    seen_d = sync_q[STAGES-1];
    mask_d = mask_q;
    if (load_en) mask_d = shadow_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      seen_q <= 1'b0;
      mask_q <= '0;
    end else begin
      sync_q <= sync_d;
      seen_q <= seen_d;
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;
  assign load_o = load_en;
endmodule

// File: rtl/cf_gate_bank.sv
module cf_gate_bank #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] gate_o,
  output logic [W-1:0] gclk_o
);
  for (genvar g = 0; g < W; g++) begin : g_lane
    logic gate_q, gate_d, upd_en;

    // the freeze state may move only while this raw clock is low
    assign upd_en = ~raw_i[g];

    always_comb begin
      gate_d = gate_q;
      if (upd_en) gate_d = mask_i[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) gate_q <= 1'b0;
      else         gate_q <= gate_d;
    end

    assign gate_o[g] = gate_q;
    assign gclk_o[g] = raw_i[g] & ~gate_q;
  end
endmodule

// File: rtl/clk_freeze_ctrl.sv
module clk_freeze_ctrl
  import clk_freeze_pkg::*;
#(
  parameter int unsigned NUM_OUT    = CF_NUM_OUT,
  parameter int unsigned SYNC_DEPTH = CF_SYNC_DEPTH
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_OUT-1:0] raw_clk_i,
  input  logic               ser_clk_i,
  input  logic               ser_data_i,
  input  logic               ser_load_i,
  output logic [NUM_OUT-1:0] gclk_o
);
  logic               rst_fast_n;
  logic               rst_ser_n;
  logic [NUM_OUT-1:0] shadow;
  logic               commit_tog;
  logic [NUM_OUT-1:0] mask_q;
  logic               load_pulse;
  logic [NUM_OUT-1:0] gate_q;

  cf_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst_fast (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_fast_n)
  );

  cf_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst_ser (
    .clk_i  (ser_clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_ser_n)
  );

  cf_serial_rx #(.W(NUM_OUT)) u_rx (
    .sclk_i   (ser_clk_i),
    .srst_ni  (rst_ser_n),
    .sdat_i   (ser_data_i),
    .sload_i  (ser_load_i),
    .shadow_o (shadow),
    .toggle_o (commit_tog)
  );

  cf_mask_xfer #(.W(NUM_OUT), .STAGES(SYNC_DEPTH)) u_xfer (
    .clk_i    (clk_i),
    .rst_ni   (rst_fast_n),
    .shadow_i (shadow),
    .toggle_i (commit_tog),
    .mask_o   (mask_q),
    .load_o   (load_pulse)
  );

  cf_gate_bank #(.W(NUM_OUT)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_fast_n),
    .raw_i  (raw_clk_i),
    .mask_i (mask_q),
    .gate_o (gate_q),
    .gclk_o (gclk_o)
  );
endmodule

// File: rtl/cf_freeze_checker.sv
module cf_freeze_checker #(
  parameter int unsigned W = 12
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] raw_i,
  input logic [W-1:0] gclk_i,
  input logic [W-1:0] gate_i,
  input logic [W-1:0] mask_i,
  input logic         load_i
);
  // R4: the active mask moves only on a commit pulse from the crossing
  p_mask_steady_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mask_i) |-> $past(load_i));

  for (genvar g = 0; g < W; g++) begin : g_bit
    // R5: a frozen lane shows low
    p_frozen_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gate_i[g] |-> !gclk_i[g]);

    // R6: freeze state moves only where the raw clock was low
    p_gate_when_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gate_i[g] != $past(gate_i[g])) |-> !$past(raw_i[g]));

    // R6: an output rises only together with its raw clock
    p_rise_with_raw_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gclk_i[g]) |-> $rose(raw_i[g]));

    // R6: a high output is never cut short while the raw clock stays high
    p_no_cut_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(gclk_i[g]) && $past(raw_i[g]) && raw_i[g]) |-> gclk_i[g]);
  end
endmodule

bind clk_freeze_ctrl cf_freeze_checker #(.W(NUM_OUT)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .raw_i  (raw_clk_i),
  .gclk_i (gclk_o),
  .gate_i (gate_q),
  .mask_i (mask_q),
  .load_i (load_pulse)
);

// File: tb/tb_clk_freeze_ctrl.sv
module tb_clk_freeze_ctrl;
  localparam int N = 12;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic [N-1:0] raw;
  logic         sclk, sdat, sld;
  wire  [N-1:0] gclk;

  always #2 clk = ~clk;

  clk_freeze_ctrl dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .raw_clk_i  (raw),
    .ser_clk_i  (sclk),
    .ser_data_i (sdat),
    .ser_load_i (sld),
    .gclk_o     (gclk)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model state
  int           div_n [N];
  int           phase [N];
  int           hi_len[N];
  bit [N-1:0]   m_gate, m_mask, m_shadow, prev_g;
  int           pend;
  int           ser_edges;
  bit           bitq[$];
  string        req;
  logic         d_sclk, d_sdat, d_sld;

  function automatic int hi_of(int i);
    return (div_n[i] + 1) / 2;
  endfunction

  task automatic check(bit ok, string r, string what, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", r, what, act, exp, $time);
    end
  endtask

  task automatic update_raw();
    for (int i = 0; i < N; i++) raw[i] = (phase[i] < hi_of(i));
  endtask

  // serial model: runs when the serial clock rises
  task automatic ser_model();
    ser_edges++;
    if (ser_edges <= 2) return;          // reset release in the serial domain
    if (sld) begin
      if (bitq.size() >= N) begin        // R3: last 12 bits, MSB first (R2)
        for (int k = 0; k < N; k++) m_shadow[N-1-k] = bitq[bitq.size()-N+k];
        pend = 3;                        // R8: third fast rising edge
      end
      bitq.delete();                     // R4: short frames dropped
    end else begin
      bitq.push_back(sdat);
    end
  endtask

  task automatic tick();
    logic [N-1:0] exp;
    @(posedge clk);
    if (rst_ni) begin
      for (int i = 0; i < N; i++) if (!raw[i]) m_gate[i] = m_mask[i];
      if (pend > 0) begin
        pend--;
        if (pend == 0) m_mask = m_shadow;
      end
    end
    @(negedge clk);
    exp = raw & ~m_gate;
    check(gclk === exp, req, "gated outputs vs model", gclk, exp);
    for (int i = 0; i < N; i++) begin
      if (gclk[i]) hi_len[i]++;
      else if (prev_g[i]) begin
        if (hi_len[i] > 0)
          check(hi_len[i] == hi_of(i), "R6", "pulse width", N'(hi_len[i]), N'(hi_of(i)));
        hi_len[i] = 0;
      end
    end
    prev_g = gclk;
    for (int i = 0; i < N; i++) phase[i] = (phase[i] + 1) % div_n[i];
    update_raw();
    sdat = d_sdat;
    sld  = d_sld;
    if (!sclk && d_sclk && rst_ni) begin
      sclk = 1'b1;
      ser_model();
    end else begin
      sclk = d_sclk;
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic ser_edge(bit d, bit ld);
    d_sdat = d; d_sld = ld; d_sclk = 1'b0;
    tick();
    d_sclk = 1'b1;
    tick();
    tick();
    d_sclk = 1'b0;
    tick();
  endtask

  task automatic send_frame(logic [31:0] val, int nbits);
    for (int k = nbits - 1; k >= 0; k--) ser_edge(val[k], 1'b0);
    ser_edge(1'b0, 1'b1);
    idle(8);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    m_gate = '0; m_mask = '0; pend = 0; ser_edges = 0;
    bitq.delete();
    for (int i = 0; i < N; i++) hi_len[i] = -100000;
    idle(5);
    rst_ni = 1'b1;
    idle(3);
    for (int k = 0; k < 3; k++) ser_edge(1'b0, 1'b1);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      div_n[i] = 2 + i; phase[i] = 0; hi_len[i] = -100000;
    end
    update_raw();
    prev_g = '0; m_shadow = '0;
    sclk = 1'b0; sdat = 1'b0; sld = 1'b0;
    d_sclk = 1'b0; d_sdat = 1'b0; d_sld = 1'b0;
    rst_ni = 1'b0;

    req = "R1";
    do_reset();
    idle(30);

    req = "R2 R5";
    send_frame(32'hA5A, N);
    idle(40);

    req = "R5";
    send_frame(32'hFFF, N);
    idle(40);

    req = "R7";
    send_frame(32'h000, N);
    idle(40);

    req = "R4";
    send_frame(32'h3C3, N);
    send_frame(32'h1F, 5);
    idle(40);

    req = "R3";
    send_frame(32'h5E81, 15);
    idle(40);

    req = "R8";
    for (int r = 0; r < 30; r++) begin
      send_frame(32'($urandom_range(0, 4095)), N);
      idle($urandom_range(0, 20));
    end

    req = "R1";
    send_frame(32'hFFF, N);
    idle(10);
    do_reset();
    idle(40);

    req = "R7";
    for (int r = 0; r < 10; r++) begin
      send_frame(32'($urandom_range(0, 4095)), N);
      idle($urandom_range(0, 25));
    end
    send_frame(32'h000, N);
    idle(40);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule